// File: doc/BRIEF.md
# Seven-Level Interrupt Priority Controller

This block gathers seven level-sensitive interrupt request lines into a pending register. Each clock it picks the highest-numbered pending line and presents it to a processor in two forms. The first is a 3-bit priority level equal to the line index plus one. The second is an autovector number equal to a fixed base plus the line index. When nothing is pending, both outputs read zero.

A single-cycle non-maskable pulse forces the top line (index 6) pending, so the processor sees level 7. The block also keeps a 64-bit count for each line of how many times its pending bit has gone from low to high.

Software reads the counters and the pending register through a plain combinational read port. This port has no handshake: the data follows the select input within the same cycle. No stream flows through the block, so all pins are plain control and status signals. Reset is synchronous and active high.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While `rst` is high, a clock edge clears the pending register, every counter and both outputs to zero.
- R2: Read select 7 returns the 8-bit pending register, zero-extended. Its bit i equals the level of `irq_req[i]` sampled at the last clock edge, and bit 7 is always 0. A line driven low clears its bit at the next edge, so nothing is latched.
- R3: Priority is fixed, and the highest set pending bit wins regardless of which lower bits are also set.
- R4: `ipl_level` equals the winning index plus one (range 1..7). It is registered from the pending register, so it reflects inputs sampled two clock edges earlier.
- R5: `vec_num` equals `VEC_BASE` (default 24) plus the winning index, with the same timing as `ipl_level`.
- R6: When no pending bit is set, `ipl_level` and `vec_num` are both 0.
- R7: Read select i (0..6) returns line i's 64-bit counter. The counter increments by exactly one on each edge where that pending bit goes from 0 to 1. A line held high does not count again.
- R8: A one-cycle `nmi_pulse` sets pending bit 6 at the next edge, giving level 7 and vector `VEC_BASE+6`. Bit 6 then follows `irq_req[6]`: it clears at the following edge if that input is low and stays set while it is high.
- R9: An NMI pulse counts as a rise of line 6 only if bit 6 was clear. An NMI pulse coinciding with a rise of `irq_req[6]` increments the counter once. An NMI pulse while bit 6 is already set does not increment it.
- R10: Several lines rising on the same edge each increment their own counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 7 | Level-sensitive request lines, bit i = line i |
| nmi_pulse | input | 1 | One-cycle non-maskable request on line 6 |
| rd_sel | input | 3 | Read select: 0..6 counters, 7 pending register |
| rd_data | output | 64 | Combinational read data |
| ipl_level | output | 3 | Registered priority level, 0 = none |
| vec_num | output | 8 | Registered autovector number, 0 = none |

## Verification
Two pairs of functions can fall in the same cycle, and both are provoked on purpose. First, the NMI injection and the ordinary request path can hit line 6 on the same edge. The bench pulses `nmi_pulse` on the edge where `irq_req[6]` rises, and again while that line is already held high. It then judges the line-6 counter (one step, then none) and level 7 against a model that counts only rises of the pending bit. Second, the NMI injection and the priority scan coincide: a pulse is raised while lower lines are pending, and the outputs must switch to level 7 and then fall back to the lower winner.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LINE_CNT = 7;
  localparam int LVL_W    = $clog2(LINE_CNT + 1);
  localparam int PEND_W   = 8;
  localparam int SEL_W    = $clog2(LINE_CNT + 1);

  typedef logic [LINE_CNT-1:0] line_vec_t;
  typedef logic [PEND_W-1:0]   pend_vec_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_prio_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_vec_t req,
  input  logic      nmi,
  output pend_vec_t pend,
  output line_vec_t rise
);
  pend_vec_t nxt;

  always_comb begin
    nxt = '0;
    nxt[LINE_CNT-1:0] = req;
    nxt[LINE_CNT-1]   = req[LINE_CNT-1] | nmi;
  end

  // a line rises when its pending bit goes from clear to set
  assign rise = rst ? '0 : (nxt[LINE_CNT-1:0] & ~pend[LINE_CNT-1:0]);

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= nxt;
  end

  // R8: injection forces the top bit at the next edge
  a_r8_nmi_sets: assert property (@(posedge clk) disable iff (rst)
    nmi |=> pend[LINE_CNT-1]);
  // R8: top bit drops once the line is low and no pulse is present
  a_r8_top_clears: assert property (@(posedge clk) disable iff (rst)
    (!nmi && !req[LINE_CNT-1]) |=> !pend[LINE_CNT-1]);
  // R2: a low line leaves its bit clear
  a_r2_low_clears: assert property (@(posedge clk) disable iff (rst)
    !req[0] |=> !pend[0]);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_prio_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24
) (
  input  pend_vec_t         pend,
  output logic [LVL_W-1:0]  lvl,
  output logic [VEC_W-1:0]  vec
);
  always_comb begin
    lvl = '0;
    vec = '0;
    // ascending scan, later (higher) indices overwrite lower ones
    for (int i = 0; i < LINE_CNT; i++) begin
      if (pend[i]) begin
        lvl = LVL_W'(i + 1);
        vec = VEC_W'(VEC_BASE + i);
      end
    end
  end
endmodule

// File: rtl/irq_stat_ctr.sv
module irq_stat_ctr
  import irq_prio_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  line_vec_t        rise,
  input  pend_vec_t        pend,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CNT_W-1:0] rd_data
);
  logic [CNT_W-1:0] cnt_q [LINE_CNT];

  for (genvar g = 0; g < LINE_CNT; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)          cnt_q[g] <= '0;
      else if (rise[g]) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end

    // R7: a counter moves by at most one per edge
    a_r7_single_step: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (cnt_q[g] == $past(cnt_q[g]) ||
                cnt_q[g] == $past(cnt_q[g]) + CNT_W'(1)));
  end

  always_comb begin
    if (int'(rd_sel) < LINE_CNT) rd_data = cnt_q[rd_sel];
    else                         rd_data = CNT_W'(pend);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [6:0]       irq_req,
  input  logic             nmi_pulse,
  input  logic [2:0]       rd_sel,
  output logic [CNT_W-1:0] rd_data,
  output logic [2:0]       ipl_level,
  output logic [VEC_W-1:0] vec_num
);
  pend_vec_t          pend;
  line_vec_t          rise;
  logic [LVL_W-1:0]   lvl_c;
  logic [VEC_W-1:0]   vec_c;

  irq_pend_reg u_pend (
    .clk (clk), .rst (rst), .req (irq_req), .nmi (nmi_pulse),
    .pend (pend), .rise (rise)
  );

  irq_prio_enc #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_enc (
    .pend (pend), .lvl (lvl_c), .vec (vec_c)
  );

  irq_stat_ctr #(.CNT_W(CNT_W)) u_stat (
    .clk (clk), .rst (rst), .rise (rise), .pend (pend),
    .rd_sel (rd_sel), .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ipl_level <= '0;
      vec_num   <= '0;
    end else begin
      ipl_level <= lvl_c;
      vec_num   <= vec_c;
    end
  end

  // R6: empty pending register gives zero outputs one edge later
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (ipl_level == '0 && vec_num == '0));
  // R3: the top line always wins
  a_r3_top_wins: assert property (@(posedge clk) disable iff (rst)
    pend[LINE_CNT-1] |=> (ipl_level == 3'd7));
  // R4/R5: level and vector name the same line
  a_r5_vec_matches_level: assert property (@(posedge clk) disable iff (rst)
    (ipl_level != '0) |-> (vec_num == VEC_W'(VEC_BASE + int'(ipl_level) - 1)));
  // R1: reset clears outputs
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (ipl_level == '0 && vec_num == '0));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
`timescale 1ns/1ps
module tb_irq_prio_ctrl;
  logic        clk = 0;
  logic        rst;
  logic [6:0]  irq_req;
  logic        nmi_pulse;
  logic [2:0]  rd_sel;
  logic [63:0] rd_data;
  logic [2:0]  ipl_level;
  logic [7:0]  vec_num;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0]  m_pend;
  logic [63:0] m_cnt [7];
  logic [2:0]  e_lvl;
  logic [7:0]  e_vec;

  always #2 clk = ~clk;

  irq_prio_ctrl dut (
    .clk (clk), .rst (rst), .irq_req (irq_req), .nmi_pulse (nmi_pulse),
    .rd_sel (rd_sel), .rd_data (rd_data), .ipl_level (ipl_level), .vec_num (vec_num)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus and advance the model
  task automatic step(logic [6:0] req, logic nmi);
    logic [7:0] np;
    @(negedge clk);
    irq_req = req; nmi_pulse = nmi;
    @(posedge clk);
    e_lvl = 0; e_vec = 0;
    for (int i = 0; i < 7; i++)
      if (m_pend[i]) begin e_lvl = 3'(i + 1); e_vec = 8'(24 + i); end
    np = {1'b0, req[6] | nmi, req[5:0]};
    for (int i = 0; i < 7; i++) if (np[i] && !m_pend[i]) m_cnt[i]++;
    m_pend = np;
    #1;
    nmi_pulse = 0;
  endtask

  task automatic chk_out(string tag);
    check({tag, " level"}, 64'(ipl_level), 64'(e_lvl));
    check({tag, " vector"}, 64'(vec_num), 64'(e_vec));
  endtask

  task automatic chk_rd(string tag, int sel, logic [63:0] exp);
    rd_sel = 3'(sel);
    #0.1;
    check(tag, rd_data, exp);
  endtask

  task automatic t_reset();
    rst = 1; irq_req = 7'h7f; nmi_pulse = 0; rd_sel = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 level", 64'(ipl_level), 0);
    check("R1 vector", 64'(vec_num), 0);
    chk_rd("R1 pending", 7, 0);
    for (int i = 0; i < 7; i++) chk_rd("R1 counter", i, 0);
    @(negedge clk); rst = 0; irq_req = 0;
    m_pend = 0; for (int i = 0; i < 7; i++) m_cnt[i] = 0;
    step(0, 0); step(0, 0);
    chk_out("R6 idle");
  endtask

  task automatic t_single_lines();
    for (int i = 0; i < 7; i++) begin
      step(7'(1 << i), 0);
      chk_rd("R2 pending follows", 7, 64'(1 << i));
      step(7'(1 << i), 0);
      chk_out("R4 R5 single line");
      step(0, 0);
      chk_rd("R2 pending cleared", 7, 0);
    end
    step(0, 0);
    chk_out("R6 after lines");
  endtask

  task automatic t_priority();
    logic [6:0] pat [5] = '{7'b0000011, 7'b0010101, 7'b1000001, 7'b0111110, 7'b0100000};
    foreach (pat[k]) begin
      step(pat[k], 0);
      step(pat[k], 0);
      chk_out("R3 priority");
    end
    step(0, 0); step(0, 0);
    chk_out("R6 drained");
  endtask

  task automatic t_counter_hold();
    for (int c = 0; c < 5; c++) step(7'b0000100, 0);
    chk_rd("R7 held line counts once", 2, m_cnt[2]);
    step(0, 0); step(7'b0000100, 0);
    chk_rd("R7 second rise", 2, m_cnt[2]);
    step(7'b0001011, 0);
    chk_rd("R10 line0", 0, m_cnt[0]);
    chk_rd("R10 line1", 1, m_cnt[1]);
    chk_rd("R10 line3", 3, m_cnt[3]);
    step(0, 0);
  endtask

  task automatic t_nmi_low();
    step(7'b0000110, 1);
    chk_rd("R8 bit6 set", 7, 64'h46);
    chk_rd("R9 nmi counts", 6, m_cnt[6]);
    step(7'b0000110, 0);
    chk_out("R8 level7");
    chk_rd("R8 bit6 clears", 7, 64'h06);
    step(7'b0000110, 0);
    chk_out("R8 back to lower winner");
    step(0, 0);
  endtask

  task automatic t_nmi_collide();
    step(7'b1000000, 1);
    chk_rd("R9 coincident rise counts once", 6, m_cnt[6]);
    step(7'b1000000, 1);
    chk_rd("R9 nmi while set no count", 6, m_cnt[6]);
    step(7'b1000000, 0);
    chk_out("R8 stays level7");
    chk_rd("R8 bit6 stays", 7, 64'h40);
    step(0, 0); step(0, 0);
    chk_out("R6 after nmi");
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single_lines();
    t_priority();
    t_counter_hold();
    t_nmi_low();
    t_nmi_collide();
    for (int i = 0; i < 7; i++) chk_rd("R7 final counter", i, m_cnt[i]);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule